// File: doc/BRIEF.md
# Indirect Switch Register Access Engine

This block lets on-chip logic read or write one 16-bit register inside an Ethernet switch whose internal registers are not directly visible on the management bus. The switch exposes only two registers there: a command register at bus register 0 and a data register at bus register 1. The engine takes a single request naming a device/port number, a register number, a direction and, for a write, the value. It then runs the whole indirect sequence and reports the outcome.

It talks to the outside world through an abstract management-bus port. Each transaction on that port carries a PHY address, a bus register number, a read/write flag and 16 bits of write data, and completes on a one-cycle acknowledge that also returns read data and an error flag. The engine polls the busy flag in the command register before each step that needs it, and gives up after a bounded number of re-reads. Any bus error aborts the request at once. The serial bit timing of the real management bus sits outside this block.

Top module: `sw_indirect_access`

## Requirements
- R1: A command word written to bus register 0 is {4'b1001, op, port[4:0], reg[4:0]}, with op = 2'b10 for a read request and op = 2'b01 for a write request.
- R2: Only the low 5 bits of `req_port` and `req_reg` are used; the upper bits do not appear in any transaction.
- R3: A read request performs, in order: busy polling of bus register 0, a write of the command word to bus register 0, busy polling again, and one read of bus register 1.
- R4: A write request performs, in order: busy polling of bus register 0, a write of `req_wdata` to bus register 1, a write of the command word to bus register 0, and busy polling again.
- R5: A poll reads bus register 0 and passes when bit 15 of the returned data is 0, whatever the other bits hold. After MAX_POLLS+1 consecutive busy reads, the request ends with error code 2 (timeout). A pass on the last allowed read still succeeds.
- R6: A transaction acknowledged with `mb_err` high ends the request with error code 1 (bus error), and no further transaction is issued for it.
- R7: `req_ready` is high only while no request is in progress. A request is taken on `req_valid && req_ready`, and `req_ready` is low in the next cycle.
- R8: `done` pulses for one cycle, in the cycle after the final acknowledge. `rsp_err` is 0 on success. `rsp_rdata` carries the data of the bus register 1 read for a successful read, and is 0 otherwise.
- R9: `mb_phy` carries the `phy_addr` value captured when the request was taken, even if `phy_addr` changes later.
- R10: While `mb_req` is high and not yet acknowledged, the transaction fields stay stable. The next transaction, if any, is presented in the cycle after the acknowledge.
- R11: After reset, `req_ready` is 1 and `done` and `mb_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | SEL_W | Target device/port number (low 5 bits used) |
| req_reg | input | SEL_W | Target register number (low 5 bits used) |
| req_wdata | input | 16 | Value for a write request |
| phy_addr | input | 5 | Bus address of the indirect register pair |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| rsp_err | output | 2 | 0 ok, 1 bus error, 2 busy timeout |
| mb_req | output | 1 | Bus transaction pending |
| mb_ack | input | 1 | Bus transaction complete |
| mb_write | output | 1 | 1 = bus write, 0 = bus read |
| mb_phy | output | 5 | Bus PHY address |
| mb_reg | output | 5 | Bus register number |
| mb_wdata | output | 16 | Bus write data |
| mb_rdata | input | 16 | Bus read data, valid with ack |
| mb_err | input | 1 | Bus error, valid with ack |

## Verification
The hardest cases to reach are the edges of the poll limit: a switch that stays busy for exactly MAX_POLLS reads and then frees up, and one that stays busy one read longer. Errors that strike in the middle of a sequence are just as hard to hit. The bench reaches them with a switch model that is told, for each request, how many busy replies to give before and after the command write and which transaction to fail. It also varies the acknowledge latency, so that back-to-back transactions and transactions held over several cycles both occur.

// File: rtl/sia_pkg.sv
package sia_pkg;
    localparam int FLD_W  = 5;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_POLL_PRE  = 3'd1,
        ST_WDATA     = 3'd2,
        ST_WCMD      = 3'd3,
        ST_POLL_POST = 3'd4,
        ST_RDATA     = 3'd5
    } sia_state_e;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_BUS     = 2'd1,
        RSP_TIMEOUT = 2'd2
    } sia_code_e;

    localparam logic [3:0] CMD_TAG = 4'b1001;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [FLD_W-1:0] BUS_REG_CMD  = 5'd0;
    localparam logic [FLD_W-1:0] BUS_REG_DATA = 5'd1;
    localparam int BUSY_BIT = 15;
endpackage

// File: rtl/sia_cmd_pack.sv
module sia_cmd_pack
    import sia_pkg::*;
(
    input  logic                 wr,
    input  logic [FLD_W-1:0]     port,
    input  logic [FLD_W-1:0]     rg,
    output logic [WORD_W-1:0]    word
);
    logic [1:0] op;

    always_comb begin
        op   = wr ? OP_WR : OP_RD;
        word = {CMD_TAG, op, port, rg};
    end
endmodule

// File: rtl/sia_poll_ctr.sv
module sia_poll_ctr #(
    parameter int MAX_POLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
        at_limit = (cnt_q == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sw_indirect_access.sv
module sw_indirect_access
    import sia_pkg::*;
#(
    parameter int SEL_W     = 8,
    parameter int MAX_POLLS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [SEL_W-1:0]  req_port,
    input  logic [SEL_W-1:0]  req_reg,
    input  logic [15:0]       req_wdata,
    input  logic [4:0]        phy_addr,
    output logic              done,
    output logic [15:0]       rsp_rdata,
    output logic [1:0]        rsp_err,
    output logic              mb_req,
    input  logic              mb_ack,
    output logic              mb_write,
    output logic [4:0]        mb_phy,
    output logic [4:0]        mb_reg,
    output logic [15:0]       mb_wdata,
    input  logic [15:0]       mb_rdata,
    input  logic              mb_err
);
    typedef struct packed {
        sia_state_e         st;
        logic               wr;
        logic [FLD_W-1:0]   port;
        logic [FLD_W-1:0]   rg;
        logic [WORD_W-1:0]  wdata;
        logic [4:0]         phy;
        logic               done;
        logic [WORD_W-1:0]  rdata;
        sia_code_e          code;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              poll_clr, poll_inc, poll_at_limit;
    logic              in_poll, busy_seen, finish;
    sia_code_e         fin_code;
    logic [WORD_W-1:0] cmd_word;

    generate
        if (SEL_W > FLD_W) begin : g_sel_drop
            logic unused_sel_hi;
            assign unused_sel_hi = ^{req_port[SEL_W-1:FLD_W], req_reg[SEL_W-1:FLD_W]};
        end
    endgenerate

    sia_cmd_pack u_pack (
        .wr   (ctx_q.wr),
        .port (ctx_q.port),
        .rg   (ctx_q.rg),
        .word (cmd_word)
    );

    sia_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .at_limit (poll_at_limit)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        in_poll    = (ctx_q.st == ST_POLL_PRE) || (ctx_q.st == ST_POLL_POST);
        busy_seen  = mb_rdata[BUSY_BIT];
        poll_clr   = !in_poll;
        poll_inc   = 1'b0;
        finish     = 1'b0;
        fin_code   = RSP_OK;

        if (ctx_q.st == ST_IDLE) begin
            if (req_valid) begin
                ctx_d.st    = ST_POLL_PRE;
                ctx_d.wr    = req_write;
                ctx_d.port  = req_port[FLD_W-1:0];
                ctx_d.rg    = req_reg[FLD_W-1:0];
                ctx_d.wdata = req_wdata;
                ctx_d.phy   = phy_addr;
            end
        end else if (mb_ack) begin
            if (mb_err) begin
                finish   = 1'b1;
                fin_code = RSP_BUS;
            end else begin
                case (ctx_q.st)
                    ST_POLL_PRE, ST_POLL_POST: begin
                        if (busy_seen) begin
                            if (poll_at_limit) begin
                                finish   = 1'b1;
                                fin_code = RSP_TIMEOUT;
                            end else begin
                                poll_inc = 1'b1;
                            end
                        end else if (ctx_q.st == ST_POLL_PRE) begin
                            ctx_d.st = ctx_q.wr ? ST_WDATA : ST_WCMD;
                        end else if (ctx_q.wr) begin
                            finish = 1'b1;
                        end else begin
                            ctx_d.st = ST_RDATA;
                        end
                    end
                    ST_WDATA: ctx_d.st = ST_WCMD;
                    ST_WCMD:  ctx_d.st = ST_POLL_POST;
                    ST_RDATA: finish   = 1'b1;
                    default:  finish   = 1'b1;
                endcase
            end
        end

        if (finish) begin
            ctx_d.st    = ST_IDLE;
            ctx_d.done  = 1'b1;
            ctx_d.code  = fin_code;
            ctx_d.rdata = ((ctx_q.st == ST_RDATA) && (fin_code == RSP_OK)) ? mb_rdata : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        req_ready = (ctx_q.st == ST_IDLE);
        done      = ctx_q.done;
        rsp_rdata = ctx_q.rdata;
        rsp_err   = ctx_q.code;
        mb_req    = (ctx_q.st != ST_IDLE);
        mb_write  = (ctx_q.st == ST_WDATA) || (ctx_q.st == ST_WCMD);
        mb_phy    = ctx_q.phy;
        mb_reg    = ((ctx_q.st == ST_WDATA) || (ctx_q.st == ST_RDATA)) ? BUS_REG_DATA : BUS_REG_CMD;
        mb_wdata  = (ctx_q.st == ST_WDATA) ? ctx_q.wdata : cmd_word;
    end
endmodule

// File: rtl/sia_checker.sv
module sia_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic [15:0] rsp_rdata,
    input logic [1:0]  rsp_err,
    input logic        mb_req,
    input logic        mb_ack,
    input logic        mb_write,
    input logic [4:0]  mb_phy,
    input logic [4:0]  mb_reg,
    input logic [15:0] mb_wdata,
    input logic        mb_err
);
    // R10
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req && !mb_ack |=> mb_req && $stable(mb_write) && $stable(mb_reg)
                              && $stable(mb_phy) && $stable(mb_wdata));

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && mb_req);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && (rsp_err != 2'd0) |-> rsp_rdata == 16'h0000);

    // R1
    cmd_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req && mb_write && (mb_reg == 5'd0) |-> mb_wdata[15:12] == 4'b1001);

    // R6
    bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_req && mb_ack && mb_err |=> done && (rsp_err == 2'd1) && !mb_req);
endmodule

bind sw_indirect_access sia_checker u_sia_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .mb_req    (mb_req),
    .mb_ack    (mb_ack),
    .mb_write  (mb_write),
    .mb_phy    (mb_phy),
    .mb_reg    (mb_reg),
    .mb_wdata  (mb_wdata),
    .mb_err    (mb_err)
);

// File: tb/tb_sw_indirect_access.sv
`timescale 1ns/1ps
module tb_sw_indirect_access;
    localparam int MAXP = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_port = '0;
    logic [7:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [4:0]  phy_addr = '0;
    logic        done;
    logic [15:0] rsp_rdata;
    logic [1:0]  rsp_err;
    logic        mb_req;
    logic        mb_ack = 1'b0;
    logic        mb_write;
    logic [4:0]  mb_phy;
    logic [4:0]  mb_reg;
    logic [15:0] mb_wdata;
    logic [15:0] mb_rdata = '0;
    logic        mb_err = 1'b0;

    always #2.5 clk = ~clk;

    sw_indirect_access #(.SEL_W(8), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_port(req_port), .req_reg(req_reg),
        .req_wdata(req_wdata), .phy_addr(phy_addr), .done(done),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mb_req(mb_req), .mb_ack(mb_ack),
        .mb_write(mb_write), .mb_phy(mb_phy), .mb_reg(mb_reg), .mb_wdata(mb_wdata),
        .mb_rdata(mb_rdata), .mb_err(mb_err)
    );

    typedef struct {
        bit          wr;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [15:0] rd;
        bit          er;
    } txn_t;

    txn_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          lat = 0;
    int          wcnt = 0;
    bit          model_busy = 0;
    bit          fin_pending = 0;
    bit          monitor_on = 0;
    logic [4:0]  exp_phy = '0;
    logic [1:0]  exp_code = '0;
    logic [15:0] exp_rdata = '0;
    bit          exp_wr = 0;
    string       cw_tag = "R1";
    string       code_tag = "R8";
    int          plan_n = 0;
    int          plan_err_at = -1;
    bit          plan_stop = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic add_txn(input bit wr, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] rd);
        txn_t t;
        if (plan_stop) return;
        t.wr = wr; t.rg = rg; t.wd = wd; t.rd = rd;
        t.er = (plan_n == plan_err_at);
        q.push_back(t);
        plan_n++;
        if (t.er) begin
            plan_stop = 1;
            exp_code  = 2'd1;
        end
    endtask

    task automatic add_polls(input int nbusy, input logic [15:0] cw);
        for (int k = 0; k <= MAXP; k++) begin
            bit busy;
            if (plan_stop) break;
            busy = (k < nbusy);
            add_txn(1'b0, 5'd0, cw, busy ? 16'hFFFF : 16'h5A5A);
            if (!busy) break;
            if ((k == MAXP) && !plan_stop) begin
                plan_stop = 1;
                exp_code  = 2'd2;
            end
        end
    endtask

    task automatic run_req(input bit wr, input logic [7:0] p, input logic [7:0] r,
                           input logic [15:0] wd, input logic [4:0] phy,
                           input int pre_b, input int post_b, input int err_at,
                           input logic [15:0] rdv, input int latency,
                           input bit move_phy);
        logic [15:0] cw;
        cw = {4'b1001, (wr ? 2'b01 : 2'b10), p[4:0], r[4:0]};
        plan_n = 0; plan_stop = 0; plan_err_at = err_at; exp_code = 2'd0;
        q.delete();
        add_polls(pre_b, cw);
        if (wr) add_txn(1'b1, 5'd1, wd, 16'h0000);
        add_txn(1'b1, 5'd0, cw, 16'h0000);
        add_polls(post_b, cw);
        if (!wr) add_txn(1'b0, 5'd1, cw, rdv);
        exp_rdata = (!wr && exp_code == 2'd0) ? rdv : 16'h0000;
        exp_phy   = phy;
        exp_wr    = wr;
        lat       = latency;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_port = p; req_reg = r;
        req_wdata = wd; phy_addr = phy;
        @(posedge clk); #1;
        req_valid = 1'b0;
        model_busy = 1;
        if (move_phy) phy_addr = ~phy;
        req_port = 8'hFF; req_reg = 8'hFF; req_wdata = 16'hDEAD;
        wait (model_busy == 0);
        repeat (3) @(posedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && monitor_on) begin
            if (fin_pending) begin
                chk(done == 1'b1, "R8", "done pulse", done, 1);
                chk(rsp_err == exp_code, code_tag, "error code", rsp_err, exp_code);
                chk(rsp_rdata == exp_rdata, "R8", "response data", rsp_rdata, exp_rdata);
                fin_pending = 0;
                model_busy  = 0;
            end else begin
                chk(done == 1'b0, "R8", "no done", done, 0);
            end
            chk(req_ready == !model_busy, "R7", "ready", req_ready, !model_busy);
            if (mb_ack) begin
                mb_ack = 1'b0; mb_err = 1'b0; wcnt = 0;
            end
            if (mb_req) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected bus transaction", {27'd0, mb_reg}, 0);
                end else begin
                    txn_t t;
                    t = q[0];
                    chk(mb_phy == exp_phy, "R9", "phy address", mb_phy, exp_phy);
                    chk(mb_write == t.wr, exp_wr ? "R4" : "R3", "bus direction", mb_write, t.wr);
                    chk(mb_reg == t.rg, exp_wr ? "R4" : "R3", "bus register", mb_reg, t.rg);
                    if (t.wr) chk(mb_wdata == t.wd, (t.rg == 5'd0) ? cw_tag : "R4",
                                  "bus write data", mb_wdata, t.wd);
                    if (wcnt >= lat) begin
                        void'(q.pop_front());
                        mb_ack = 1'b1; mb_rdata = t.rd; mb_err = t.er;
                        if (q.size() == 0) fin_pending = 1;
                    end else begin
                        if (wcnt > 0) chk(mb_req == 1'b1, "R10", "held request", mb_req, 1);
                        wcnt++;
                    end
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
        chk(done == 1'b0, "R11", "done after reset", done, 0);
        chk(mb_req == 1'b0, "R11", "bus idle after reset", mb_req, 0);
        monitor_on = 1;

        // R3 plain read, back-to-back acks
        run_req(0, 8'd3, 8'd4, 16'h0, 5'd16, 0, 0, -1, 16'hBEEF, 0, 0);
        // R4 write with busy phases before and after
        run_req(1, 8'd27, 8'd4, 16'hC400, 5'd16, 2, 3, -1, 16'h0, 1, 0);
        // R2 upper select bits dropped
        cw_tag = "R2";
        run_req(0, 8'hE5, 8'h3F, 16'h0, 5'd7, 1, 1, -1, 16'h1357, 2, 0);
        run_req(1, 8'hA2, 8'h61, 16'h00FF, 5'd7, 0, 0, -1, 16'h0, 0, 0);
        cw_tag = "R1";
        // R5 busy for exactly the limit, then free
        code_tag = "R5";
        run_req(0, 8'd1, 8'd2, 16'h0, 5'd2, MAXP, 0, -1, 16'h4242, 0, 0);
        // R5 busy one read too long before the command
        run_req(0, 8'd1, 8'd2, 16'h0, 5'd2, MAXP + 1, 0, -1, 16'h4242, 0, 0);
        // R5 timeout in the closing poll of a write
        run_req(1, 8'd9, 8'd9, 16'h1111, 5'd2, 0, MAXP + 5, -1, 16'h0, 0, 0);
        // R6 bus error on the command write of a write request
        code_tag = "R6";
        run_req(1, 8'd5, 8'd6, 16'h2222, 5'd3, 0, 0, 2, 16'h0, 1, 0);
        // R6 bus error on the very first poll
        run_req(0, 8'd5, 8'd6, 16'h0, 5'd3, 0, 0, 0, 16'h0, 0, 0);
        // R6 bus error on the final data read
        run_req(0, 8'd5, 8'd6, 16'h0, 5'd3, 1, 1, 5, 16'h9999, 2, 0);
        code_tag = "R8";
        // R9 phy input moves after acceptance; R10 long ack latency
        run_req(0, 8'd12, 8'd30, 16'h0, 5'd21, 1, 2, -1, 16'h0F0F, 3, 1);
        run_req(1, 8'd31, 8'd31, 16'hFFFF, 5'd31, 1, 0, -1, 16'h0, 3, 1);
        // recovery read after errors
        run_req(0, 8'd0, 8'd0, 16'h0, 5'd0, 0, 0, -1, 16'h0001, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule